// File: doc/BRIEF.md
# Four-Channel Scaled-Compare PWM Timer

This block is a memory-mapped timer built around one 31-bit up-counter that four compare channels share. Each channel compares a 16-bit slice of the counter against its own compare register. The slice starts at the bit picked by a 4-bit scale field, so a channel can time long intervals without a wide comparator. A channel whose slice value reaches or passes its compare value latches a pending flag. Its interrupt line follows that flag as a level until software clears it.

Software reaches the block over a plain 32-bit register bus: an address, a write strobe, write data, and combinational read data. Through that bus it sets the scale and enables, loads the counter directly or through the scaled view, and programs the compare values. The counter can run freely or as a one-shot. In one-shot mode it stops when channel 0 resets it in zero-on-compare mode, or when it wraps.

Top module: `pwm4_timer`

## Requirements
- R1: After a synchronous active-low reset, the configuration, counter and compare registers read zero and every irq line is low.
- R2: The counter advances by one each clock while configuration bit 12 (free-run enable) or bit 13 (one-shot enable) is 1. It holds its value while both are 0.
- R3: The counter is 31 bits wide, reads at address 0x08 with bit 31 zero, and wraps from 0x7FFFFFFF to 0.
- R4: Address 0x10 reads the scaled view. This is the counter shifted right by configuration bits 3:0, keeping the low 16 bits.
- R5: Compare register i sits at address 0x20+4*i and keeps 16 bits. When the scaled view is greater than or equal to compare i, pending bit i (configuration bit 28+i, driven on irq[i]) is 1 from the next clock on.
- R6: A pending bit stays set until a configuration write carries 0 in its position. If a match occurs in the same cycle as that write, the bit stays set.
- R7: While configuration bit 9 is 1, a channel-0 match sets the counter to 0 and clears bit 13 at the next clock.
- R8: A counter wrap while the counter runs clears bit 13, which stops a one-shot run at zero.
- R9: A write to 0x08 loads the counter with write data bits 30:0. This takes precedence over increment and zero-on-compare.
- R10: A write to 0x10 loads the counter with the low 16 write-data bits shifted left by the current scale, truncated to 31 bits.
- R11: A write to address 0x00 stores all 32 bits. Writing 1 into bits 31:28 sets the pending bits. Bits 8, 10, 16 to 19 and 24 to 27 read back but change nothing else.
- R12: Reads of unmapped addresses return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the addressed register, combinational |
| irq | output | 4 | Per-channel level interrupt, equal to the pending bit |

## Verification
The hardest case to reach from the ports is the carry-out of the 31-bit counter. Counting up to it would take over two billion clocks. The stimulus loads the counter a few counts below 0x7FFFFFFF through the counter register, then starts a one-shot run and watches the run stop at zero. A second hard case is a software clear landing in the same cycle as a live match. The bench forces this by programming a compare value of zero, so that channel matches every cycle, and then writing a configuration value with that pending bit cleared.

// File: rtl/pwm4_pkg.sv
// pwm4_pkg: register addresses and configuration field positions shared by
// the PWM timer and its sub-blocks. Assumes a 32-bit configuration word.
package pwm4_pkg;
    localparam int unsigned ADR_CFG    = 'h00;
    localparam int unsigned ADR_CNT    = 'h08;
    localparam int unsigned ADR_SCALED = 'h10;
    localparam int unsigned ADR_CMP0   = 'h20;
    localparam int unsigned ADR_STRIDE = 4;

    localparam int unsigned B_ZERO_ON_CMP = 9;
    localparam int unsigned B_FREE_RUN    = 12;
    localparam int unsigned B_ONE_SHOT    = 13;
    localparam int unsigned IP_LSB        = 28;
endpackage

// File: rtl/pwm4_counter.sv
// pwm4_counter: the shared free-running counter.
// Assumes at most one of ld_raw / ld_scaled is high in any cycle.
// Priority: software load, then zero-on-compare, then increment.
module pwm4_counter #(
    parameter int CNT_W = 31,
    parameter int CMP_W = 16,
    parameter int SCL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ld_raw,
    input  logic             ld_scaled,
    input  logic             zero_req,
    input  logic [CNT_W-1:0] wdata,
    input  logic [SCL_W-1:0] scale,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] sval;

    // Scaled-load value: 16-bit window shifted into counter position.
    always_comb sval = CNT_W'({{(CNT_W-CMP_W){1'b0}}, wdata[CMP_W-1:0]}) << scale;

    // Carry-out: running counter at its top value.
    always_comb wrap = run && (cnt_q == CNT_MAX);

    // Counter register update.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (ld_raw)     cnt_q <= wdata;
        else if (ld_scaled)  cnt_q <= sval;
        else if (zero_req)   cnt_q <= '0;
        else if (run)        cnt_q <= cnt_q + 1'b1;
    end

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_raw && !ld_scaled && !zero_req && !wrap) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_raw && !ld_scaled && !zero_req) |=> $stable(cnt_q));
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ld_raw && !ld_scaled) |=> cnt_q == '0);
    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_req && !ld_raw && !ld_scaled) |=> cnt_q == '0);
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_raw |=> cnt_q == $past(wdata));
    p_sload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_scaled |=> cnt_q == $past(sval));
endmodule

// File: rtl/pwm4_chan.sv
// pwm4_chan: one compare channel. Compares the scaled counter view with its
// compare value and keeps the pending flag. A match overrides a software
// write in the same cycle.
module pwm4_chan #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] scaled,
    input  logic [CMP_W-1:0] cmp,
    input  logic             sw_wr,
    input  logic             sw_ip,
    output logic             match,
    output logic             ip_q
);
    // Threshold compare on the scaled window.
    always_comb match = (scaled >= cmp);

    // Pending flag: set by match, else written by software, else held.
    always_ff @(posedge clk) begin
        if (!rst_n)     ip_q <= 1'b0;
        else if (match) ip_q <= 1'b1;
        else if (sw_wr) ip_q <= sw_ip;
    end

    p_match_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> ip_q);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_q && !sw_wr) |=> ip_q);
    p_sw_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !sw_ip && !match) |=> !ip_q);
endmodule

// File: rtl/pwm4_timer.sv
// pwm4_timer: four-channel scaled-compare timer with a 32-bit register bus.
// Assumes NCH == 4 so the pending bits fill configuration bits 31:28.
// Reads are combinational; writes take effect at the next clock.
module pwm4_timer
    import pwm4_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 31,
    parameter int CMP_W  = 16,
    parameter int SCL_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic [NCH-1:0]    irq
);
    localparam int CFG_LO_W = IP_LSB;

    logic [CFG_LO_W-1:0]        cfg_q;
    logic [NCH-1:0][CMP_W-1:0]  cmp_q;
    logic [NCH-1:0]             ip_q;
    logic [NCH-1:0]             match;
    logic [NCH-1:0]             sel_cmp;
    logic [CNT_W-1:0]           cnt_q;
    logic [CMP_W-1:0]           scaled;
    logic [SCL_W-1:0]           scale;
    logic sel_cfg, sel_cnt, sel_scl, mapped;
    logic run, zero_req, wrap;

    // Address decode.
    always_comb begin
        sel_cfg = (addr == ADDR_W'(ADR_CFG));
        sel_cnt = (addr == ADDR_W'(ADR_CNT));
        sel_scl = (addr == ADDR_W'(ADR_SCALED));
        for (int i = 0; i < NCH; i++)
            sel_cmp[i] = (addr == ADDR_W'(ADR_CMP0 + ADR_STRIDE * i));
        mapped = sel_cfg | sel_cnt | sel_scl | (|sel_cmp);
    end

    // Control decoded from configuration.
    always_comb begin
        scale    = cfg_q[SCL_W-1:0];
        run      = cfg_q[B_FREE_RUN] | cfg_q[B_ONE_SHOT];
        scaled   = CMP_W'(cnt_q >> scale);
        zero_req = cfg_q[B_ZERO_ON_CMP] & match[0];
    end

    // Configuration register; hardware clear of one-shot wins over a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            if (wr_en && sel_cfg) cfg_q <= wr_data[CFG_LO_W-1:0];
            if (zero_req || wrap) cfg_q[B_ONE_SHOT] <= 1'b0;
        end
    end

    pwm4_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCL_W(SCL_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .ld_raw    (wr_en && sel_cnt),
        .ld_scaled (wr_en && sel_scl),
        .zero_req  (zero_req),
        .wdata     (wr_data[CNT_W-1:0]),
        .scale     (scale),
        .cnt_q     (cnt_q),
        .wrap      (wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Compare register for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)                 cmp_q[g] <= '0;
            else if (wr_en && sel_cmp[g]) cmp_q[g] <= wr_data[CMP_W-1:0];
        end

        pwm4_chan #(.CMP_W(CMP_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .scaled (scaled),
            .cmp    (cmp_q[g]),
            .sw_wr  (wr_en && sel_cfg),
            .sw_ip  (wr_data[IP_LSB+g]),
            .match  (match[g]),
            .ip_q   (ip_q[g])
        );
    end

    assign irq = ip_q;

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        if (sel_cfg) rd_data = {ip_q, cfg_q};
        if (sel_cnt) rd_data = 32'(cnt_q);
        if (sel_scl) rd_data = 32'(scaled);
        for (int i = 0; i < NCH; i++)
            if (sel_cmp[i]) rd_data = 32'(cmp_q[i]);
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (cfg_q == '0 && cmp_q == '0 && irq == '0 && cnt_q == '0));
    p_wrap_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !cfg_q[B_ONE_SHOT]);
    p_zero_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |=> !cfg_q[B_ONE_SHOT]);
    p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped && !zero_req && !wrap) |=> ($stable(cfg_q) && $stable(cmp_q)));
endmodule

// File: tb/pwm4_timer_test.sv
module pwm4_timer_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state
    logic [31:0] m_cfg;
    longint      m_cnt;
    int          m_cmp [4];
    localparam longint MASK31 = 64'h7FFF_FFFF;

    always #4 clk = ~clk;

    pwm4_timer uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic longint m_scaled();
        return (m_cnt >> m_cfg[3:0]) & 64'hFFFF;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_cfg;
            8'h08: return 32'(m_cnt);
            8'h10: return 32'(m_scaled());
            8'h20: return 32'(m_cmp[0]);
            8'h24: return 32'(m_cmp[1]);
            8'h28: return 32'(m_cmp[2]);
            8'h2C: return 32'(m_cmp[3]);
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_tick(input bit w, input logic [7:0] a, input logic [31:0] d, input bit rn);
        logic [31:0] nc;
        longint ncnt;
        bit hit [4];
        bit run, zr, wr;
        if (!rn) begin
            m_cfg = '0; m_cnt = 0;
            foreach (m_cmp[i]) m_cmp[i] = 0;
            return;
        end
        for (int i = 0; i < 4; i++) hit[i] = (m_scaled() >= longint'(m_cmp[i]));
        run = m_cfg[12] || m_cfg[13];
        zr  = m_cfg[9] && hit[0];
        wr  = run && (m_cnt == MASK31);
        nc = m_cfg;
        if (w && a == 8'h00) nc = d;
        if (zr || wr) nc[13] = 1'b0;
        for (int i = 0; i < 4; i++) if (hit[i]) nc[28+i] = 1'b1;
        ncnt = m_cnt;
        if (w && a == 8'h08)      ncnt = longint'(d) & MASK31;
        else if (w && a == 8'h10) ncnt = ((longint'(d) & 64'hFFFF) << m_cfg[3:0]) & MASK31;
        else if (zr)              ncnt = 0;
        else if (run)             ncnt = (m_cnt + 1) & MASK31;
        for (int i = 0; i < 4; i++)
            if (w && a == 8'(8'h20 + 4*i)) m_cmp[i] = int'(d & 32'hFFFF);
        m_cfg = nc;
        m_cnt = ncnt;
    endtask

    task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d, input string tag);
        logic [31:0] e_rd;
        logic [3:0]  e_irq;
        @(negedge clk);
        rst_n = rst_req; wr_en = w; addr = a; wr_data = d;
        #1;
        if (tag != "") begin
            vectors++;
            e_rd = m_read(a);
            e_irq = m_cfg[31:28];
            if (rd_data !== e_rd || irq !== e_irq) begin
                fails++;
                $display("FAIL %s addr=%h rd_data=%h expected=%h irq=%b expected=%b",
                         tag, a, rd_data, e_rd, irq, e_irq);
            end
        end
        @(posedge clk);
        model_tick(w, a, d, rst_n);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b0, a, '0, tag);
    endtask

    initial begin
        #(8ns * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        m_cfg = '0; m_cnt = 0;
        foreach (m_cmp[i]) m_cmp[i] = 0;
        rst_req = 1'b0;
        repeat (3) rd(8'h00, "");
        rst_req = 1'b1;
        // R1: reset values
        rd(8'h00, "R1"); rd(8'h08, "R1"); rd(8'h20, "R1");
        // R5: compare registers keep 16 bits
        wr(8'h20, 32'h0001_2345, "R5");
        wr(8'h24, 32'hFFFF, "R5"); wr(8'h28, 32'hFFFF, "R5"); wr(8'h2C, 32'hFFFF, "R5");
        rd(8'h20, "R5"); rd(8'h2C, "R5");
        // R6: software clear, then stays clear without matches
        wr(8'h00, 32'h0, "R6");
        repeat (3) rd(8'h00, "R6");
        // R2/R5: free run, channel 1 fires
        wr(8'h24, 32'd20, "R5");
        wr(8'h00, 32'h0000_1000, "R2");
        repeat (25) rd(8'h08, "R2");
        rd(8'h10, "R4");
        // R4: scale 2 window, channel 2 fires
        wr(8'h00, 32'h0000_1002, "R4");
        wr(8'h28, 32'd12, "R5");
        repeat (30) rd(8'h10, "R4");
        // R2: stop and hold
        wr(8'h00, 32'h0000_0002, "R2");
        repeat (5) rd(8'h08, "R2");
        // R6: clear write concurrent with live match
        wr(8'h2C, 32'h0, "R6");
        rd(8'h00, "R6");
        wr(8'h00, 32'h0000_0002, "R6");
        rd(8'h00, "R6");
        // R7: zero-on-compare in one-shot
        wr(8'h2C, 32'hFFFF, "R7");
        wr(8'h08, 32'h0, "R9");
        wr(8'h20, 32'd10, "R7");
        wr(8'h00, 32'h0000_2200, "R7");
        repeat (20) rd(8'h08, "R7");
        rd(8'h00, "R7");
        // R8 / R3: wrap ends one-shot
        wr(8'h20, 32'hFFFF, "R8");
        wr(8'h08, 32'hFFFF_FFFD, "R3");
        rd(8'h08, "R3");
        wr(8'h00, 32'h0000_2000, "R8");
        repeat (6) rd(8'h00, "R8");
        rd(8'h08, "R3");
        // R3: free-run wrap continues
        wr(8'h08, 32'h7FFF_FFFE, "R3");
        wr(8'h00, 32'h0000_1000, "R3");
        repeat (4) rd(8'h08, "R3");
        // R9: load while running
        wr(8'h08, 32'd100, "R9");
        rd(8'h08, "R9"); rd(8'h08, "R9");
        // R10: scaled loads
        wr(8'h00, 32'h0000_0004, "R10");
        wr(8'h10, 32'hABCD_1234, "R10");
        rd(8'h08, "R10"); rd(8'h10, "R10");
        wr(8'h00, 32'h0000_000F, "R10");
        wr(8'h10, 32'h0000_FFFF, "R10");
        rd(8'h08, "R10"); rd(8'h10, "R10");
        // R11: inert bits stored, pending set by write
        wr(8'h00, 32'h0F0F_0500, "R11");
        rd(8'h00, "R11");
        repeat (3) rd(8'h08, "R11");
        wr(8'h00, 32'hF000_0000, "R11");
        rd(8'h00, "R11");
        // R12: unmapped addresses
        wr(8'h04, 32'hFFFF_FFFF, "R12");
        wr(8'h30, 32'hFFFF_FFFF, "R12");
        wr(8'h26, 32'h0000_1111, "R12");
        rd(8'h04, "R12"); rd(8'hFC, "R12");
        rd(8'h00, "R12"); rd(8'h24, "R12"); rd(8'h08, "R12");
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule